// File: doc/BRIEF.md
# Load/Store Endianness Mapping Unit

This unit sits between a processor's load/store datapath and a 32-bit memory port. For each access it takes the request's size, address, signedness and store data, plus the memory words read for loads. It then produces the memory-side byte address, the byte-lane enable mask, the lane-placed store data and the register-side load results. Results appear on registered outputs one clock after the request is accepted.

Three endianness models are supported. In little-endian mode, bytes map straight onto lanes. The word-invariant big-endian model keeps data untouched and instead flips the lane address of byte and halfword accesses. The byte-invariant big-endian model leaves addresses alone and reverses the bytes inside halfword and word values. The word-invariant control and the unaligned-handling control are quasi-static configuration. The byte-invariant control is sampled with every access. Enabling both big-endian models at once is illegal, and the unit flags such an access.

For two-word (double-precision) transfers, the unit also decides which memory word belongs to which register of a register pair.

Top module: `ldst_endian_map`

## Requirements
- R1: Byte access: the lane is address bits [1:0] in little-endian mode and those bits XOR 2'b11 when `cfg_word_inv`=1. `mem_addr` carries the address with its low two bits replaced by the lane. `mem_be` has only the bit for that lane set (bit i = bytes [8i+7:8i]).
- R2: Halfword access: address bit 0 is ignored. The lane pair starts at lane {addr[1],0}, and bit 1 is inverted when `cfg_word_inv`=1. `mem_be` is 4'b0011 shifted to that pair. When `req_byte_inv`=1, the two bytes of the value are exchanged.
- R3: Word access: `mem_be`=4'b1111 and `mem_addr[1:0]`=0. When `req_byte_inv`=1, the four bytes of the value are reversed. In the other two modes the word is passed unchanged.
- R4: Word load with `cfg_true_unaligned`=0: the memory word is rotated right by 8*addr[1:0] bits before any byte-invariant reversal. With `cfg_true_unaligned`=1, no rotation is applied.
- R5: Two-word access (`req_size`=3) from base A: in little-endian mode, the word at A belongs to the low register (`rd_data_lo` / `req_wdata_lo`) and the word at A+4 to the high register. When either big-endian control is 1, this pairing is swapped. Under `req_byte_inv`=1, each word is also byte-reversed.
- R6: Byte and halfword load results are zero-extended to 32 bits when `req_signed`=0 and sign-extended when it is 1.
- R7: Store outputs: lanes outside `mem_be` carry zero in `mem_wdata_lo`. `mem_wdata_hi` is zero except for two-word stores. Load results are zero for stores, and store data outputs are zero for loads.
- R8: An access with `cfg_word_inv`=1 and `req_byte_inv`=1 raises `out_mode_err`. In that case `mem_addr`, `mem_be` and every data output are zero.
- R9: Each accepted request produces exactly one `out_valid` pulse on the following cycle. No pulse appears without a request. Reset clears every output to zero.
- R10: `req_byte_inv` takes effect per access: back-to-back requests alternating it are each mapped under their own setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 two-word |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_addr | input | ADDR_W | Byte address from the datapath |
| cfg_true_unaligned | input | 1 | 1 = no rotation of unaligned word loads |
| cfg_word_inv | input | 1 | Word-invariant big-endian enable |
| req_byte_inv | input | 1 | Byte-invariant big-endian enable, per access |
| req_wdata_lo | input | 32 | Store data from the low register |
| req_wdata_hi | input | 32 | Store data from the high register (two-word) |
| mem_rdata_lo | input | 32 | Memory word at the base address (loads) |
| mem_rdata_hi | input | 32 | Memory word at base+4 (two-word loads) |
| out_valid | output | 1 | Result registers hold a new access |
| out_mode_err | output | 1 | Illegal mode combination on that access |
| mem_addr | output | ADDR_W | Mapped memory byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata_lo | output | 32 | Lane-placed store data for the base word |
| mem_wdata_hi | output | 32 | Store data for the word at base+4 |
| rd_data_lo | output | 32 | Load result for the low register |
| rd_data_hi | output | 32 | Load result for the high register |

## Verification
Every size is tried under each of the three legal modes. Each uses memory words whose bytes are all distinct, so a wrong lane, a missing swap or a misplaced rotation shows up as a different value. Byte and halfword loads are repeated at every lane offset, with lanes holding values whose top bit is set, to separate sign extension from zero extension. Word loads at all four offsets, with and without the unaligned control, tell rotation apart from plain passing. Two-word loads and stores in all three modes confirm the register pairing. Alternating the byte-invariant control on consecutive cycles, an illegal mode request and an idle gap show that modes are sampled per access, that illegal requests produce no output data, and that no spurious result appears.

// File: rtl/ldst_endian_pkg.sv
package ldst_endian_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int LANE_W = $clog2(BYTES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_DUAL = 2'd3
  } acc_size_e;

  // Reverse the byte order of a word.
  function automatic logic [WORD_W-1:0] flip_bytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < BYTES; i++) begin
      r[8*i +: 8] = w[8*(BYTES-1-i) +: 8];
    end
    return r;
  endfunction

  // Rotate a word right by a whole number of bytes.
  function automatic logic [WORD_W-1:0] rot_bytes(input logic [WORD_W-1:0] w,
                                                  input logic [LANE_W-1:0] amt);
    logic [2*WORD_W-1:0] d;
    d = {w, w} >> {amt, 3'b000};
    return d[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/ldst_lane_sel.sv
module ldst_lane_sel
  import ldst_endian_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  input  logic              word_inv,
  output logic [ADDR_W-1:0] map_addr,
  output logic [LANE_W-1:0] lane,
  output logic [BYTES-1:0]  lane_en
);
  always_comb begin
    case (size)
      ACC_BYTE: begin
        lane    = addr[LANE_W-1:0] ^ {LANE_W{word_inv}};
        lane_en = BYTES'(1) << lane;
      end
      ACC_HALF: begin
        lane    = {addr[1] ^ word_inv, 1'b0};
        lane_en = BYTES'(3) << lane;
      end
      default: begin
        lane    = '0;
        lane_en = '1;
      end
    endcase
    map_addr = {addr[ADDR_W-1:LANE_W], lane};
  end
endmodule

// File: rtl/ldst_load_path.sv
module ldst_load_path
  import ldst_endian_pkg::*;
(
  input  acc_size_e         size,
  input  logic              sgn,
  input  logic              byte_inv,
  input  logic              rotate_en,
  input  logic [LANE_W-1:0] rot_amt,
  input  logic [LANE_W-1:0] lane,
  input  logic              pair_swap,
  input  logic [WORD_W-1:0] mem_lo,
  input  logic [WORD_W-1:0] mem_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi
);
  logic [7:0]        pick8;
  logic [15:0]       pick16;
  logic [WORD_W-1:0] whole;
  logic [WORD_W-1:0] first_w;
  logic [WORD_W-1:0] second_w;

  always_comb begin
    pick8  = mem_lo[{lane, 3'b000} +: 8];
    pick16 = mem_lo[{lane[1], 4'b0000} +: 16];
    if (byte_inv) pick16 = {pick16[7:0], pick16[15:8]};

    whole = rotate_en ? rot_bytes(mem_lo, rot_amt) : mem_lo;
    if (byte_inv) whole = flip_bytes(whole);

    first_w  = byte_inv ? flip_bytes(mem_lo) : mem_lo;
    second_w = byte_inv ? flip_bytes(mem_hi) : mem_hi;

    res_lo = '0;
    res_hi = '0;
    case (size)
      ACC_BYTE: res_lo = {{(WORD_W-8){sgn & pick8[7]}}, pick8};
      ACC_HALF: res_lo = {{(WORD_W-16){sgn & pick16[15]}}, pick16};
      ACC_WORD: res_lo = whole;
      default: begin
        res_lo = pair_swap ? second_w : first_w;
        res_hi = pair_swap ? first_w  : second_w;
      end
    endcase
  end
endmodule

// File: rtl/ldst_store_path.sv
module ldst_store_path
  import ldst_endian_pkg::*;
(
  input  acc_size_e         size,
  input  logic              byte_inv,
  input  logic [BYTES-1:0]  lane_en,
  input  logic              pair_swap,
  input  logic [WORD_W-1:0] reg_lo,
  input  logic [WORD_W-1:0] reg_hi,
  output logic [WORD_W-1:0] out_lo,
  output logic [WORD_W-1:0] out_hi
);
  logic [15:0]       half_v;
  logic [WORD_W-1:0] spread;
  logic [WORD_W-1:0] base_w;
  logic [WORD_W-1:0] next_w;

  always_comb begin
    half_v = byte_inv ? {reg_lo[7:0], reg_lo[15:8]} : reg_lo[15:0];
    base_w = pair_swap ? reg_hi : reg_lo;
    next_w = pair_swap ? reg_lo : reg_hi;
    if (byte_inv) begin
      base_w = flip_bytes(base_w);
      next_w = flip_bytes(next_w);
    end
    case (size)
      ACC_BYTE: spread = {BYTES{reg_lo[7:0]}};
      ACC_HALF: spread = {(BYTES/2){half_v}};
      ACC_WORD: spread = byte_inv ? flip_bytes(reg_lo) : reg_lo;
      default:  spread = base_w;
    endcase
    out_hi = (size == ACC_DUAL) ? next_w : '0;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign out_lo[8*i +: 8] = lane_en[i] ? spread[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/ldst_endian_map.sv
module ldst_endian_map
  import ldst_endian_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_true_unaligned,
  input  logic              cfg_word_inv,
  input  logic              req_byte_inv,
  input  logic [31:0]       req_wdata_lo,
  input  logic [31:0]       req_wdata_hi,
  input  logic [31:0]       mem_rdata_lo,
  input  logic [31:0]       mem_rdata_hi,
  output logic              out_valid,
  output logic              out_mode_err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata_lo,
  output logic [31:0]       mem_wdata_hi,
  output logic [31:0]       rd_data_lo,
  output logic [31:0]       rd_data_hi
);
  acc_size_e         size_c;
  logic              bad_mode;
  logic              pair_swap;
  logic [ADDR_W-1:0] map_addr;
  logic [LANE_W-1:0] lane;
  logic [BYTES-1:0]  lane_en;
  logic [WORD_W-1:0] ld_lo, ld_hi, st_lo, st_hi;
  acc_size_e         size_q;
  logic              store_q;

  assign size_c    = acc_size_e'(req_size);
  assign bad_mode  = cfg_word_inv & req_byte_inv;
  assign pair_swap = cfg_word_inv | req_byte_inv;

  ldst_lane_sel #(.ADDR_W(ADDR_W)) u_lane (
    .addr     (req_addr),
    .size     (size_c),
    .word_inv (cfg_word_inv),
    .map_addr (map_addr),
    .lane     (lane),
    .lane_en  (lane_en)
  );

  ldst_load_path u_load (
    .size      (size_c),
    .sgn       (req_signed),
    .byte_inv  (req_byte_inv),
    .rotate_en (~cfg_true_unaligned),
    .rot_amt   (req_addr[LANE_W-1:0]),
    .lane      (lane),
    .pair_swap (pair_swap),
    .mem_lo    (mem_rdata_lo),
    .mem_hi    (mem_rdata_hi),
    .res_lo    (ld_lo),
    .res_hi    (ld_hi)
  );

  ldst_store_path u_store (
    .size      (size_c),
    .byte_inv  (req_byte_inv),
    .lane_en   (lane_en),
    .pair_swap (pair_swap),
    .reg_lo    (req_wdata_lo),
    .reg_hi    (req_wdata_hi),
    .out_lo    (st_lo),
    .out_hi    (st_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_mode_err <= 1'b0;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata_lo <= '0;
      mem_wdata_hi <= '0;
      rd_data_lo   <= '0;
      rd_data_hi   <= '0;
      size_q       <= ACC_BYTE;
      store_q      <= 1'b0;
    end else begin
      out_valid    <= req_valid;
      out_mode_err <= req_valid & bad_mode;
      size_q       <= size_c;
      store_q      <= req_store;
      if (req_valid && !bad_mode) begin
        mem_addr     <= map_addr;
        mem_be       <= lane_en;
        mem_wdata_lo <= req_store ? st_lo : '0;
        mem_wdata_hi <= req_store ? st_hi : '0;
        rd_data_lo   <= req_store ? '0 : ld_lo;
        rd_data_hi   <= req_store ? '0 : ld_hi;
      end else begin
        mem_addr     <= '0;
        mem_be       <= '0;
        mem_wdata_lo <= '0;
        mem_wdata_hi <= '0;
        rd_data_lo   <= '0;
        rd_data_hi   <= '0;
      end
    end
  end

  // R8
  err_outputs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode_err) |-> (mem_be == '0 && rd_data_lo == '0 &&
                                     rd_data_hi == '0 && mem_wdata_lo == '0));
  // R8
  err_only_both_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(cfg_word_inv && req_byte_inv)) |=> !out_mode_err);
  // R1
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_mode_err && size_q == ACC_BYTE) |->
      ($countones(mem_be) == 1 && mem_be[mem_addr[1:0]]));
  // R3
  wide_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_mode_err && size_q[1]) |->
      (mem_addr[1:0] == 2'b00 && mem_be == 4'b1111));
  // R7
  load_no_wdata_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !store_q) |-> (mem_wdata_lo == '0 && mem_wdata_hi == '0));
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
endmodule

// File: tb/ldst_endian_map_tb_top.sv
`timescale 1ns/1ps
module ldst_endian_map_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_store = 0, req_signed = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_addr = 0;
  logic        cfg_true_unaligned = 0, cfg_word_inv = 0, req_byte_inv = 0;
  logic [31:0] req_wdata_lo = 0, req_wdata_hi = 0, mem_rdata_lo = 0, mem_rdata_hi = 0;
  logic        out_valid, out_mode_err;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata_lo, mem_wdata_hi, rd_data_lo, rd_data_hi;

  always #2.5 clk = ~clk;

  ldst_endian_map #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .cfg_true_unaligned(cfg_true_unaligned), .cfg_word_inv(cfg_word_inv),
    .req_byte_inv(req_byte_inv), .req_wdata_lo(req_wdata_lo),
    .req_wdata_hi(req_wdata_hi), .mem_rdata_lo(mem_rdata_lo),
    .mem_rdata_hi(mem_rdata_hi), .out_valid(out_valid),
    .out_mode_err(out_mode_err), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata_lo(mem_wdata_lo), .mem_wdata_hi(mem_wdata_hi),
    .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi)
  );

  typedef struct packed {
    logic        err;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wlo, whi, rlo, rhi;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;

  function automatic logic [31:0] rev32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Reference built from memory byte addresses, per the requirements.
  function automatic exp_t model(input bit st, input int sz, input bit sg,
                                 input logic [31:0] ad, input bit u, input bit b,
                                 input bit e, input logic [31:0] wl,
                                 input logic [31:0] wh, input logic [31:0] ml,
                                 input logic [31:0] mh);
    exp_t r;
    logic [7:0]  m [8];
    logic [31:0] v, lw, hw;
    int a, h, la;
    r = '0;
    if (b && e) begin r.err = 1; return r; end
    for (int i = 0; i < 4; i++) begin
      m[i] = ml[8*i +: 8];
      m[i+4] = mh[8*i +: 8];
    end
    a = int'(ad[1:0]);
    case (sz)
      0: begin
        la = b ? (a ^ 3) : a;
        r.addr = {ad[31:2], 2'(la)};
        r.be = 4'(1 << la);
        if (st) r.wlo[8*la +: 8] = wl[7:0];
        else begin
          v = {24'h0, m[la]};
          if (sg && m[la][7]) v[31:8] = '1;
          r.rlo = v;
        end
      end
      1: begin
        h = (a & 2) ^ (b ? 2 : 0);
        r.addr = {ad[31:2], 2'(h)};
        r.be = 4'(3 << h);
        if (st) begin
          r.wlo[8*h +: 8]     = e ? wl[15:8] : wl[7:0];
          r.wlo[8*(h+1) +: 8] = e ? wl[7:0]  : wl[15:8];
        end else begin
          v = e ? {16'h0, m[h], m[h+1]} : {16'h0, m[h+1], m[h]};
          if (sg && v[15]) v[31:16] = '1;
          r.rlo = v;
        end
      end
      2: begin
        r.addr = {ad[31:2], 2'b00};
        r.be = 4'hF;
        if (st) r.wlo = e ? rev32(wl) : wl;
        else begin
          v = {m[3], m[2], m[1], m[0]};
          if (!u) v = (v >> (8*a)) | (v << (32 - 8*a));
          r.rlo = e ? rev32(v) : v;
        end
      end
      default: begin
        r.addr = {ad[31:2], 2'b00};
        r.be = 4'hF;
        if (st) begin
          lw = (b || e) ? wh : wl;
          hw = (b || e) ? wl : wh;
          r.wlo = e ? rev32(lw) : lw;
          r.whi = e ? rev32(hw) : hw;
        end else begin
          lw = {m[3], m[2], m[1], m[0]};
          hw = {m[7], m[6], m[5], m[4]};
          if (e) begin lw = rev32(lw); hw = rev32(hw); end
          r.rlo = (b || e) ? hw : lw;
          r.rhi = (b || e) ? lw : hw;
        end
      end
    endcase
    return r;
  endfunction

  task automatic drive(input bit st, input int sz, input bit sg, input logic [31:0] ad,
                       input bit u, input bit b, input bit e, input logic [31:0] wl,
                       input logic [31:0] wh, input logic [31:0] ml,
                       input logic [31:0] mh, input string tag);
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = 2'(sz); req_signed = sg;
    req_addr = ad; cfg_true_unaligned = u; cfg_word_inv = b; req_byte_inv = e;
    req_wdata_lo = wl; req_wdata_hi = wh; mem_rdata_lo = ml; mem_rdata_hi = mh;
    exp_q.push_back(model(st, sz, sg, ad, u, b, e, wl, wh, ml, mh));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R9: out_valid with no pending request (actual 1, expected 0)");
      end else begin
        exp_t x, g;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        g = {out_mode_err, mem_addr, mem_be, mem_wdata_lo, mem_wdata_hi,
             rd_data_lo, rd_data_hi};
        if (g !== x) begin
          n_errors++;
          $display("FAIL %s: actual err=%b addr=%h be=%b wlo=%h whi=%h rlo=%h rhi=%h expected err=%b addr=%h be=%b wlo=%h whi=%h rlo=%h rhi=%h",
                   t, g.err, g.addr, g.be, g.wlo, g.whi, g.rlo, g.rhi,
                   x.err, x.addr, x.be, x.wlo, x.whi, x.rlo, x.rhi);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  localparam logic [31:0] MLO = 32'h8433_A211;
  localparam logic [31:0] MHI = 32'hF766_C855;
  localparam logic [31:0] WLO = 32'h1122_3384;
  localparam logic [31:0] WHI = 32'hA5B6_C7D8;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9: reset state
    n_checks++;
    if ({out_valid, out_mode_err, mem_addr, mem_be, mem_wdata_lo, mem_wdata_hi,
         rd_data_lo, rd_data_hi} !== '0) begin
      n_errors++;
      $display("FAIL R9: outputs after reset actual valid=%b be=%b expected all zero",
               out_valid, mem_be);
    end
    // R1, R6: byte loads in LE and word-invariant BE at all offsets, both signs
    for (int a = 0; a < 4; a++) begin
      drive(0, 0, 0, 32'h2000 + 32'(a), 0, 0, 0, 0, 0, MLO, MHI, "R1");
      drive(0, 0, 1, 32'h2000 + 32'(a), 0, 1, 0, 0, 0, MLO, MHI, "R1/R6");
      drive(0, 0, 1, 32'h2000 + 32'(a), 0, 0, 1, 0, 0, MLO, MHI, "R6");
    end
    // R2, R6: halfword loads, including odd address bit 0
    for (int a = 0; a < 4; a++) begin
      drive(0, 1, 1, 32'h3000 + 32'(a), 0, 0, 0, 0, 0, MLO, MHI, "R2/R6");
      drive(0, 1, 0, 32'h3000 + 32'(a), 0, 1, 0, 0, 0, MLO, MHI, "R2");
      drive(0, 1, 1, 32'h3000 + 32'(a), 0, 0, 1, 0, 0, MLO, MHI, "R2");
    end
    // R3, R4: word loads, rotation on and off, three modes
    for (int a = 0; a < 4; a++) begin
      drive(0, 2, 0, 32'h4000 + 32'(a), 0, 0, 0, 0, 0, MLO, MHI, "R4");
      drive(0, 2, 0, 32'h4000 + 32'(a), 1, 0, 0, 0, 0, MLO, MHI, "R4");
      drive(0, 2, 0, 32'h4000 + 32'(a), 0, 0, 1, 0, 0, MLO, MHI, "R3/R4");
      drive(0, 2, 0, 32'h4000 + 32'(a), 0, 1, 0, 0, 0, MLO, MHI, "R3");
    end
    // R5: two-word loads and stores
    drive(0, 3, 0, 32'h2000, 0, 0, 0, 0, 0, MLO, MHI, "R5");
    drive(0, 3, 0, 32'h2000, 0, 1, 0, 0, 0, MLO, MHI, "R5");
    drive(0, 3, 0, 32'h2000, 0, 0, 1, 0, 0, MLO, MHI, "R5");
    drive(1, 3, 0, 32'h2008, 0, 0, 0, WLO, WHI, MLO, MHI, "R5/R7");
    drive(1, 3, 0, 32'h2008, 0, 1, 0, WLO, WHI, MLO, MHI, "R5/R7");
    drive(1, 3, 0, 32'h2008, 0, 0, 1, WLO, WHI, MLO, MHI, "R5/R7");
    // R7: byte, halfword and word stores in all modes
    for (int a = 0; a < 4; a++) begin
      drive(1, 0, 0, 32'h5000 + 32'(a), 0, 0, 0, WLO, WHI, MLO, MHI, "R7/R1");
      drive(1, 0, 0, 32'h5000 + 32'(a), 0, 1, 0, WLO, WHI, MLO, MHI, "R7/R1");
      drive(1, 1, 0, 32'h5000 + 32'(a), 0, 0, 1, WLO, WHI, MLO, MHI, "R7/R2");
      drive(1, 1, 0, 32'h5000 + 32'(a), 0, 1, 0, WLO, WHI, MLO, MHI, "R7/R2");
      drive(1, 2, 0, 32'h5000 + 32'(a), 0, 0, 1, WLO, WHI, MLO, MHI, "R7/R3");
    end
    // R8: illegal combination, load and store
    drive(0, 2, 0, 32'h6001, 0, 1, 1, WLO, WHI, MLO, MHI, "R8");
    drive(1, 1, 0, 32'h6002, 0, 1, 1, WLO, WHI, MLO, MHI, "R8");
    // R10: byte-invariant control alternating back to back
    for (int i = 0; i < 6; i++) begin
      drive(0, 2, 0, 32'h7000, 1, 0, (i % 2 == 1), 0, 0, MLO, MHI, "R10");
      drive(1, 1, 0, 32'h7002, 1, 0, (i % 2 == 0), WLO, 0, MLO, MHI, "R10");
    end
    // R9: idle gap must produce no result
    idle(6);
    drive(0, 0, 0, 32'h8003, 0, 0, 0, 0, 0, MLO, MHI, "R9");
    idle(4);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL R9: pending results actual %0d expected 0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule